// File: doc/BRIEF.md
# HDB3 Line Receive Decoder with Code-Violation Counting

This block takes dual-rail line symbols, a positive-pulse rail and a negative-pulse rail, on a receive line clock and turns them into a recovered binary stream. Three static controls pick its behaviour. One picks which clock edge samples the rails. One picks single-rail binary input or dual-rail bipolar input. One picks plain AMI decoding or HDB3 zero-substitution decoding. In HDB3 mode, each legitimate substitution code is turned back into four zero bits. Every bipolar violation that is not a legitimate substitution raises a line-code-violation pulse.

Each violation pulse increments a saturating 16-bit event counter. The same pulse also feeds a saturating 16-bit accumulator. In HDB3 mode, a run of consecutive zero symbols that reaches the limit also counts into the accumulator, once per run. A one-second strobe copies the accumulator into a holding register and restarts the accumulator. Both counters are presented as low and high byte halves.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: With `rx_edge_sel_i`=0 the rails are captured on the rising edge of `clk_i`. With `rx_edge_sel_i`=1 they are captured on the falling edge, and the symbol enters the decoder at the following rising edge.
- R2: With `unipolar_i`=1, `data_o` follows `rx_pos_i`, `rx_neg_i` has no effect, and `lcv_o` never pulses.
- R3: In HDB3 mode (`unipolar_i`=0, `ami_mode_i`=0), a valid substitution code is output as zeros. Both the 000V form and the B00V form are covered, and in the B00V form the B bit is also zeroed. A violation is a mark with the same polarity as the previous mark. It is valid when its polarity differs from the previous violation and the three symbols before it are 000 or B00. The first violation after reset needs no alternation.
- R4: In HDB3 mode, a violation that fails either the alternation test or the pattern test raises `lcv_o` and is output as a 1.
- R5: In AMI mode (`unipolar_i`=0, `ami_mode_i`=1), every mark with the same polarity as the mark before it raises `lcv_o`, and `data_o` still carries each mark as 1.
- R6: Each `lcv_o` pulse increments the event counter by one. The counter reads as `evt_hi_o` (bits 15:8) and `evt_lo_o` (bits 7:0).
- R7: In HDB3 mode, the third consecutive zero symbol of a run adds one to the accumulator, once per run. This does not change the event counter.
- R8: When `sec_tick_i` is sampled high, the accumulator value is copied to `sec_hi_o`/`sec_lo_o` and the accumulator restarts from zero.
- R9: The event counter and the accumulator stop at 0xFFFF and do not wrap.
- R10: A symbol captured at edge n appears on `data_o` after rising edge n+4. Its violation pulse appears on `lcv_o` for one cycle after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive line clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_edge_sel_i | input | 1 | 0: rising-edge capture, 1: falling-edge capture |
| unipolar_i | input | 1 | 1: binary data on positive rail only |
| ami_mode_i | input | 1 | 1: AMI decoding, 0: HDB3 decoding |
| rx_pos_i | input | 1 | Positive-pulse rail |
| rx_neg_i | input | 1 | Negative-pulse rail |
| sec_tick_i | input | 1 | One-second strobe |
| data_o | output | 1 | Recovered binary data |
| lcv_o | output | 1 | Line code violation pulse |
| evt_lo_o | output | 8 | Event counter bits 7:0 |
| evt_hi_o | output | 8 | Event counter bits 15:8 |
| sec_lo_o | output | 8 | Latched one-second count bits 7:0 |
| sec_hi_o | output | 8 | Latched one-second count bits 15:8 |

## Verification
Streams from an encoder rarely contain bad violations, so the hardest conditions to reach from the ports are the two ways a violation can fail. These are a violation that repeats the polarity of the previous violation, and one that lacks the 000/B00 lead-in. The bench drives a hand-built symbol sequence that contains exactly one of each, between legitimate 000V and B00V codes. It then replays the same sequence in AMI mode. The counter saturation corner needs more than 65535 violations, and the bench reaches it with a long run of same-polarity marks.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;
endpackage

// File: rtl/hdb3_line_sampler.sv
module hdb3_line_sampler
  import hdb3_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  edge_sel_i,
  input  rail_t rail_i,
  output rail_t sym_o,
  output logic  vld_o
);
  rail_t fall_q, sym_q;
  logic  vld_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= rail_i;
  end

  // falling-edge capture is handed over at the next rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sym_q <= edge_sel_i ? fall_q : rail_i;
      vld_q <= 1'b1;
    end
  end

  assign sym_o = sym_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/hdb3_decode_core.sv
module hdb3_decode_core
  import hdb3_rx_pkg::*;
#(
  parameter int ZRUN_LIMIT = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vld_i,
  input  rail_t sym_i,
  input  logic  unipolar_i,
  input  logic  ami_mode_i,
  output logic  data_o,
  output logic  lcv_o,
  output logic  zrun_o
);
  localparam int ZW = $clog2(ZRUN_LIMIT + 1);

  logic [2:0]    dly_q;
  logic          out_q, lcv_q, zrun_q;
  logic          last_pol_q, last_v_pol_q, seen_mark_q, seen_v_q;
  logic [ZW-1:0] run_q;

  logic mark, pol, zero, hdb3, viol, pat_ok, alt_ok, sub_ok, lcv_d, new_bit, zr_hit;

  always_comb begin
    hdb3    = !unipolar_i && !ami_mode_i;
    mark    = unipolar_i ? sym_i.pos : (sym_i.pos | sym_i.neg);
    zero    = !mark;
    pol     = !sym_i.pos;  // 1 = negative mark
    viol    = !unipolar_i && mark && seen_mark_q && (pol == last_pol_q);
    pat_ok  = (dly_q == 3'b000) || (dly_q == 3'b100);
    alt_ok  = !seen_v_q || (pol != last_v_pol_q);
    sub_ok  = hdb3 && viol && pat_ok && alt_ok;
    lcv_d   = viol && !sub_ok;
    new_bit = mark && !sub_ok;
    zr_hit  = hdb3 && zero && (run_q == ZW'(ZRUN_LIMIT - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q        <= '0;
      out_q        <= 1'b0;
      lcv_q        <= 1'b0;
      zrun_q       <= 1'b0;
      last_pol_q   <= 1'b0;
      last_v_pol_q <= 1'b0;
      seen_mark_q  <= 1'b0;
      seen_v_q     <= 1'b0;
      run_q        <= '0;
    end else if (vld_i) begin
      // oldest bit is zeroed when the code is B00V
      out_q  <= sub_ok ? 1'b0 : dly_q[2];
      dly_q  <= {dly_q[1:0], new_bit};
      lcv_q  <= lcv_d;
      zrun_q <= zr_hit;
      if (zero) begin
        if (run_q != ZW'(ZRUN_LIMIT)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
      if (!unipolar_i && mark) begin
        last_pol_q  <= pol;
        seen_mark_q <= 1'b1;
      end
      if (viol) begin
        last_v_pol_q <= pol;
        seen_v_q     <= 1'b1;
      end
    end else begin
      lcv_q  <= 1'b0;
      zrun_q <= 1'b0;
    end
  end

  assign data_o = out_q;
  assign lcv_o  = lcv_q;
  assign zrun_o = zrun_q;
endmodule

// File: rtl/hdb3_sat_cnt.sv
module hdb3_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= W'(inc_i);
    else if (inc_i && (cnt_q != '1))    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int ZRUN_LIMIT = 3,
  localparam int HALF_W    = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_edge_sel_i,
  input  logic              unipolar_i,
  input  logic              ami_mode_i,
  input  logic              rx_pos_i,
  input  logic              rx_neg_i,
  input  logic              sec_tick_i,
  output logic              data_o,
  output logic              lcv_o,
  output logic [HALF_W-1:0] evt_lo_o,
  output logic [HALF_W-1:0] evt_hi_o,
  output logic [HALF_W-1:0] sec_lo_o,
  output logic [HALF_W-1:0] sec_hi_o
);
  rail_t            rail, sym;
  logic             sym_vld, lcv, zrun;
  logic [CNT_W-1:0] evt_cnt, acc_cnt, hold_cnt;

  assign rail = '{pos: rx_pos_i, neg: rx_neg_i};

  hdb3_line_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_sel_i (rx_edge_sel_i),
    .rail_i     (rail),
    .sym_o      (sym),
    .vld_o      (sym_vld)
  );

  hdb3_decode_core #(.ZRUN_LIMIT(ZRUN_LIMIT)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (sym_vld),
    .sym_i      (sym),
    .unipolar_i (unipolar_i),
    .ami_mode_i (ami_mode_i),
    .data_o     (data_o),
    .lcv_o      (lcv),
    .zrun_o     (zrun)
  );

  hdb3_sat_cnt #(.W(CNT_W)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .inc_i  (lcv),
    .cnt_o  (evt_cnt)
  );

  hdb3_sat_cnt #(.W(CNT_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sec_tick_i),
    .inc_i  (lcv | zrun),
    .cnt_o  (acc_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_cnt <= '0;
    else if (sec_tick_i) hold_cnt <= acc_cnt;
  end

  assign lcv_o    = lcv;
  assign evt_lo_o = evt_cnt[HALF_W-1:0];
  assign evt_hi_o = evt_cnt[CNT_W-1:HALF_W];
  assign sec_lo_o = hold_cnt[HALF_W-1:0];
  assign sec_hi_o = hold_cnt[CNT_W-1:HALF_W];
endmodule

// File: rtl/hdb3_rx_chk.sv
module hdb3_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             unipolar_i,
  input logic             sec_tick_i,
  input logic             lcv_o,
  input logic [CNT_W-1:0] evt_cnt,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [CNT_W-1:0] hold_cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R2
  uni_no_lcv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unipolar_i |=> !lcv_o);

  // R6
  evt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcv_o && evt_cnt != MAXV) |=> evt_cnt == $past(evt_cnt) + 1'b1);

  // R6
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcv_o |=> $stable(evt_cnt));

  // R8
  tick_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i |=> hold_cnt == $past(acc_cnt));

  // R9
  evt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt == MAXV |=> evt_cnt == MAXV);

  // R9
  acc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cnt == MAXV && !sec_tick_i) |=> acc_cnt == MAXV);
endmodule

bind hdb3_rx_decoder hdb3_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .unipolar_i (unipolar_i),
  .sec_tick_i (sec_tick_i),
  .lcv_o      (lcv_o),
  .evt_cnt    (evt_cnt),
  .acc_cnt    (acc_cnt),
  .hold_cnt   (hold_cnt)
);

// File: tb/sim_hdb3_rx_decoder.sv
module sim_hdb3_rx_decoder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic edge_sel = 1'b0, uni = 1'b0, ami = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0, tick = 1'b0;
  logic data_o, lcv_o;
  logic [7:0] evt_lo, evt_hi, sec_lo, sec_hi;

  always #4 clk = ~clk;

  hdb3_rx_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rx_edge_sel_i(edge_sel), .unipolar_i(uni),
    .ami_mode_i(ami), .rx_pos_i(rx_pos), .rx_neg_i(rx_neg), .sec_tick_i(tick),
    .data_o(data_o), .lcv_o(lcv_o), .evt_lo_o(evt_lo), .evt_hi_o(evt_hi),
    .sec_lo_o(sec_lo), .sec_hi_o(sec_hi)
  );

  localparam int N = 4200;
  int  n_run = 0, n_fail = 0;
  logic sp [N], sn [N], ed [N], lcv_seen [N];
  logic b [N];
  int  len, idx, zr, exp_runs;
  bit  hdb3_m, data_chk;

  int hs [28] = '{1,0,0,0,1, -1,0,0,0,-1, 1,0,0,0,1, -1,1,0,0,0,1, -1,0,-1, 1,0,0,1};
  logic hd [28] = '{1,0,0,0,0, 1,0,0,0,0, 1,0,0,0,0, 1,1,0,0,0,1, 1,0,1, 0,0,0,0};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int evt_val();
    return {evt_hi, evt_lo};
  endfunction

  task automatic step(input logic p, input logic n, input logic tk, input bit hf);
    @(posedge clk);
    #1;
    rst_ni = 1'b1; rx_pos = p; rx_neg = n; tick = tk;
    if (!(p | n)) begin
      if (zr == 2 && hdb3_m) exp_runs++;
      if (zr < 3) zr++;
    end else zr = 0;
    #4;
    if (idx < N) lcv_seen[idx] = lcv_o;
    if (data_chk && idx >= 5 && idx - 5 < len)
      chk($sformatf("R10/data[%0d]", idx - 5), int'(data_o), int'(ed[idx - 5]));
    idx++;
    if (hf) begin #1; rx_pos = 1'b0; rx_neg = 1'b0; end
  endtask

  task automatic seg_reset(input logic es, input logic u, input logic a);
    rst_ni = 1'b0; edge_sel = es; uni = u; ami = a;
    rx_pos = 1'b0; rx_neg = 1'b0; tick = 1'b0;
    zr = 0; exp_runs = 0; idx = 0; data_chk = 1'b1;
    hdb3_m = !u && !a;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic play(input int n, input bit hf);
    len = n;
    for (int i = 0; i < n; i++) step(sp[i], sn[i], 1'b0, hf);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic latch_read(output int hold);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    hold = {sec_hi, sec_lo};
  endtask

  task automatic put(input int i, input int pol);
    sp[i] = (pol > 0);
    sn[i] = (pol < 0);
  endtask

  task automatic hdb3_encode(input int n);
    int lp, nonv, i;
    lp = -1; nonv = 0; i = 0;
    while (i < n) begin
      if (i + 3 < n && !b[i] && !b[i+1] && !b[i+2] && !b[i+3]) begin
        if (nonv % 2 == 1) begin
          put(i, 0); put(i+1, 0); put(i+2, 0); put(i+3, lp);
        end else begin
          lp = -lp;
          put(i, lp); put(i+1, 0); put(i+2, 0); put(i+3, lp);
        end
        for (int k = 0; k < 4; k++) ed[i+k] = 1'b0;
        nonv = 0;
        i += 4;
      end else begin
        if (b[i]) begin lp = -lp; put(i, lp); nonv++; end
        else put(i, 0);
        ed[i] = b[i];
        i++;
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hold, ami_lcv, lastp;
    // reset state
    #3;
    chk("R6 reset evt", evt_val(), 0);
    chk("R8 reset hold", {sec_hi, sec_lo}, 0);
    chk("R10 reset data", int'(data_o), 0);
    chk("R4 reset lcv", int'(lcv_o), 0);

    // R2: unipolar, rising edge, negative rail toggling
    seg_reset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2048; i++) begin
      sp[i] = ((i >> 3) >> (i & 7)) & 1;
      sn[i] = (i >> 2) & 1;
      ed[i] = sp[i];
    end
    play(2048, 1'b0);
    chk("R2 unipolar evt", evt_val(), 0);
    latch_read(hold);
    chk("R2 unipolar acc", hold, 0);

    // R3/R7: encoded HDB3 stream, falling-edge capture
    seg_reset(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2048; i++) b[i] = ((i >> 3) >> (i & 7)) & 1;
    hdb3_encode(2048);
    play(2048, 1'b0);
    chk("R3 clean stream evt", evt_val(), 0);
    latch_read(hold);
    chk("R7 zero-run acc", hold, exp_runs);

    // R3/R4: hand-built HDB3 sequence with two bad violations
    seg_reset(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 28; i++) begin put(i, hs[i]); ed[i] = hd[i]; end
    play(28, 1'b0);
    chk("R4 lcv after alternation fault", int'(lcv_seen[22]), 1);
    chk("R4 lcv after pattern fault", int'(lcv_seen[25]), 1);
    chk("R10 no lcv before fault", int'(lcv_seen[21]), 0);
    chk("R3 no lcv on valid B00V", int'(lcv_seen[29]), 0);
    chk("R6 R7 evt excludes zero runs", evt_val(), 2);
    latch_read(hold);
    chk("R8 hold = lcv + runs", hold, 2 + exp_runs);
    latch_read(hold);
    chk("R8 accumulator restarted", hold, 0);

    // R5: same sequence in AMI mode
    seg_reset(1'b0, 1'b0, 1'b1);
    ami_lcv = 0; lastp = 0;
    for (int i = 0; i < 28; i++) begin
      put(i, hs[i]); ed[i] = (hs[i] != 0);
      if (hs[i] != 0) begin
        if (hs[i] == lastp) ami_lcv++;
        lastp = hs[i];
      end
    end
    play(28, 1'b0);
    chk("R5 ami lcv first repeat", int'(lcv_seen[6]), 1);
    chk("R5 ami evt", evt_val(), ami_lcv);
    latch_read(hold);
    chk("R5 ami acc ignores zero runs", hold, ami_lcv);

    // R1: half-width pulses only seen by falling-edge capture
    for (int es = 0; es < 2; es++) begin
      seg_reset(logic'(es), 1'b1, 1'b0);
      for (int i = 0; i < 40; i++) begin
        sp[i] = (i % 3 == 0); sn[i] = 1'b0;
        ed[i] = (es == 1) ? sp[i] : 1'b0;
      end
      play(40, 1'b1);
    end
    chk("R1 edge sweep done", 1, 1);

    // R9: saturation with repeated positive marks in AMI
    seg_reset(1'b0, 1'b0, 1'b1);
    data_chk = 1'b0;
    len = 0;
    for (int i = 0; i < 65600; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 evt saturated", evt_val(), 16'hFFFF);
    latch_read(hold);
    chk("R9 acc saturated", hold, 16'hFFFF);
    chk("R6 evt byte halves", int'(evt_hi), 8'hFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule